// File: doc/BRIEF.md
# Context Doorbell Decoder

The decoder sits behind a write-only register window that is split into one 4 KB page per user context. Software running in a context rings doorbells by writing one 32-bit word to its page. Only the offset inside the page decides which doorbell is hit, so every page maps onto the same layout. A write to the queue-pair doorbell can request a send, a receive, or both. A write to the completion-queue doorbell can request an arm, which may be limited to solicited events, and a poll. These requests are independent of each other.

Each request leaves the block on its own channel. A channel is a registered one-cycle strobe plus the object handle taken from the low bits of the written word. A write to an offset that has no doorbell, or a write narrower than 32 bits, raises no request. Instead it produces a one-cycle error strobe that carries the offending page offset. Queue processing, completion handling and reads are done elsewhere.

Top module: `ctx_doorbell_decode`

## Requirements
- R1: While reset is asserted, and in the first cycle after it is released, every request strobe and the error strobe are low.
- R2: Only address bits 11:0 select the doorbell. Writes that differ only in bits above bit 11 give identical results.
- R3: A full write to page offset 0x000 (queue-pair doorbell) with data bit 30 set pulses the send strobe. With bit 31 set it pulses the receive strobe. With both bits set, both strobes pulse in the same cycle.
- R4: A full write to page offset 0x008 (completion-queue doorbell) with data bit 30 set pulses the arm strobe. The solicited-only output beside it equals data bit 29 of that write.
- R5: At offset 0x008, data bit 31 pulses the poll strobe, whatever the state of bits 30 and 29.
- R6: Every request handle equals data bits 23:0 of the write that fired it. Data bits 28:24 have no effect on any output.
- R7: A full write to any page offset other than 0x000 and 0x008 pulses the error strobe, with the error offset equal to address bits 11:0, and fires no request.
- R8: A write whose byte strobes are not all four set fires no request and pulses the error strobe, whatever the offset. Data is little-endian: data bits 7:0 are the byte at the lowest address and are enabled by strobe bit 0.
- R9: Every strobe is registered. It rises in the cycle after the write is sampled and stays high for one cycle, unless the next write fires it again. With no write, no strobe is high.
- R10: At a doorbell offset, a data bit that selects no action of that doorbell fires nothing and raises no error. This covers bit 29 at 0x000, bit 29 alone at 0x008, and a write with no flag set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write valid this cycle |
| wr_addr | input | ADDR_W (32) | Write byte address; only the low 12 bits are decoded |
| wr_data | input | DATA_W (32) | Write data, little-endian |
| wr_strb | input | DATA_W/8 (4) | Byte enables; all set for an accepted write |
| qp_send_o | output | 1 | Send request strobe |
| qp_send_hdl_o | output | HDL_W (24) | Send request handle |
| qp_recv_o | output | 1 | Receive request strobe |
| qp_recv_hdl_o | output | HDL_W (24) | Receive request handle |
| cq_arm_o | output | 1 | Arm request strobe |
| cq_arm_hdl_o | output | HDL_W (24) | Arm request handle |
| cq_arm_sol_o | output | 1 | Arm limited to solicited events |
| cq_poll_o | output | 1 | Poll request strobe |
| cq_poll_hdl_o | output | HDL_W (24) | Poll request handle |
| err_o | output | 1 | Unsupported access strobe |
| err_off_o | output | PAGE_BITS (12) | Page offset of the unsupported access |

## Verification
Every result is due exactly one clock edge after the write is sampled: one register lies between the write port and each strobe, handle, qualifier and error offset. The bench drives each write on a falling edge and removes it on the next falling edge. At that falling edge it reads every channel, which is half a period after the register captured the result. It then checks again one falling edge later that every strobe has dropped. Back-to-back writes are checked at each of the consecutive falling edges, so a strobe that should stay high for two cycles is told apart from one that is stretched.

// File: rtl/dbell_pkg.sv
package dbell_pkg;

  // Request channel indices; the order sets the index in the channel vector.
  typedef enum logic [1:0] {
    CH_SEND = 2'd0,
    CH_RECV = 2'd1,
    CH_ARM  = 2'd2,
    CH_POLL = 2'd3
  } dbell_ch_e;

  localparam int NUM_CH = 4;

  // Doorbell selected by the page offset of an accepted write.
  typedef enum logic [1:0] {
    TGT_NONE = 2'd0,
    TGT_QP   = 2'd1,
    TGT_CQ   = 2'd2
  } dbell_tgt_e;

endpackage

// File: rtl/dbell_addr_dec.sv
module dbell_addr_dec
  import dbell_pkg::*;
#(
  parameter int PAGE_BITS = 12,
  parameter int STRB_W    = 4,
  parameter int QP_OFF    = 'h000,
  parameter int CQ_OFF    = 'h008
) (
  input  logic                 wr_en,
  input  logic [PAGE_BITS-1:0] page_off,
  input  logic [STRB_W-1:0]    wr_strb,
  output dbell_tgt_e           tgt,
  output logic                 bad_access
);

  localparam logic [PAGE_BITS-1:0] QP_OFF_L = PAGE_BITS'(QP_OFF);
  localparam logic [PAGE_BITS-1:0] CQ_OFF_L = PAGE_BITS'(CQ_OFF);

  logic full_word;
  assign full_word = &wr_strb;

  always_comb begin
    tgt        = TGT_NONE;
    bad_access = 1'b0;
    if (wr_en) begin
      if (!full_word) begin
        bad_access = 1'b1;
      end else if (page_off == QP_OFF_L) begin
        tgt = TGT_QP;
      end else if (page_off == CQ_OFF_L) begin
        tgt = TGT_CQ;
      end else begin
        bad_access = 1'b1;
      end
    end
  end

endmodule

// File: rtl/dbell_field_ext.sv
module dbell_field_ext
  import dbell_pkg::*;
#(
  parameter int DATA_W   = 32,
  parameter int HDL_W    = 24,
  parameter int SEND_BIT = 30,
  parameter int RECV_BIT = 31,
  parameter int ARM_BIT  = 30,
  parameter int SOL_BIT  = 29,
  parameter int POLL_BIT = 31
) (
  input  dbell_tgt_e         tgt,
  input  logic [DATA_W-1:0]  wr_data,
  output logic [NUM_CH-1:0]  fire,
  output logic [HDL_W-1:0]   hdl,
  output logic               sol
);

  // Bits between the handle and the flags carry no meaning.
  logic unused_data_bits;
  assign unused_data_bits = ^wr_data;

  assign hdl = wr_data[HDL_W-1:0];
  assign sol = wr_data[SOL_BIT];

  always_comb begin
    fire = '0;
    case (tgt)
      TGT_QP: begin
        fire[CH_SEND] = wr_data[SEND_BIT];
        fire[CH_RECV] = wr_data[RECV_BIT];
      end
      TGT_CQ: begin
        fire[CH_ARM]  = wr_data[ARM_BIT];
        fire[CH_POLL] = wr_data[POLL_BIT];
      end
      default: fire = '0;
    endcase
  end

endmodule

// File: rtl/dbell_chan_reg.sv
module dbell_chan_reg #(
  parameter int PAY_W = 25
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             fire_i,
  input  logic [PAY_W-1:0] pay_i,
  output logic             vld_o,
  output logic [PAY_W-1:0] pay_o
);

  logic             vld_d, vld_q;
  logic [PAY_W-1:0] pay_d, pay_q;

  always_comb begin
    vld_d = fire_i;
    pay_d = pay_q;
    if (fire_i) begin
      pay_d = pay_i;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q <= 1'b0;
      pay_q <= '0;
    end else begin
      vld_q <= vld_d;
      if (fire_i) begin
        pay_q <= pay_d;
      end
    end
  end

  assign vld_o = vld_q;
  assign pay_o = pay_q;

endmodule

// File: rtl/ctx_doorbell_decode.sv
module ctx_doorbell_decode
  import dbell_pkg::*;
#(
  parameter int ADDR_W    = 32,
  parameter int DATA_W    = 32,
  parameter int HDL_W     = 24,
  parameter int PAGE_BITS = 12,
  parameter int QP_OFF    = 'h000,
  parameter int CQ_OFF    = 'h008,
  parameter int SEND_BIT  = 30,
  parameter int RECV_BIT  = 31,
  parameter int ARM_BIT   = 30,
  parameter int SOL_BIT   = 29,
  parameter int POLL_BIT  = 31
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   wr_en,
  input  logic [ADDR_W-1:0]      wr_addr,
  input  logic [DATA_W-1:0]      wr_data,
  input  logic [DATA_W/8-1:0]    wr_strb,
  output logic                   qp_send_o,
  output logic [HDL_W-1:0]       qp_send_hdl_o,
  output logic                   qp_recv_o,
  output logic [HDL_W-1:0]       qp_recv_hdl_o,
  output logic                   cq_arm_o,
  output logic [HDL_W-1:0]       cq_arm_hdl_o,
  output logic                   cq_arm_sol_o,
  output logic                   cq_poll_o,
  output logic [HDL_W-1:0]       cq_poll_hdl_o,
  output logic                   err_o,
  output logic [PAGE_BITS-1:0]   err_off_o
);

  localparam int STRB_W = DATA_W / 8;
  localparam int PAY_W  = HDL_W + 1;

  // Page number bits do not take part in decoding.
  logic unused_page_num;
  assign unused_page_num = ^wr_addr[ADDR_W-1:PAGE_BITS];

  logic [PAGE_BITS-1:0] page_off;
  dbell_tgt_e           tgt;
  logic                 bad_access;
  logic [NUM_CH-1:0]    fire;
  logic [HDL_W-1:0]     hdl;
  logic                 sol;

  assign page_off = wr_addr[PAGE_BITS-1:0];

  dbell_addr_dec #(
    .PAGE_BITS (PAGE_BITS),
    .STRB_W    (STRB_W),
    .QP_OFF    (QP_OFF),
    .CQ_OFF    (CQ_OFF)
  ) addr_dec_i (
    .wr_en      (wr_en),
    .page_off   (page_off),
    .wr_strb    (wr_strb),
    .tgt        (tgt),
    .bad_access (bad_access)
  );

  dbell_field_ext #(
    .DATA_W   (DATA_W),
    .HDL_W    (HDL_W),
    .SEND_BIT (SEND_BIT),
    .RECV_BIT (RECV_BIT),
    .ARM_BIT  (ARM_BIT),
    .SOL_BIT  (SOL_BIT),
    .POLL_BIT (POLL_BIT)
  ) field_ext_i (
    .tgt     (tgt),
    .wr_data (wr_data),
    .fire    (fire),
    .hdl     (hdl),
    .sol     (sol)
  );

  logic [NUM_CH-1:0] ch_vld;
  logic [PAY_W-1:0]  ch_pay [NUM_CH];

  for (genvar g = 0; g < NUM_CH; g++) begin : g_chan
    logic [PAY_W-1:0] pay_in;
    if (g == int'(CH_ARM)) begin : g_qual
      assign pay_in = {sol, hdl};
    end else begin : g_plain
      assign pay_in = {1'b0, hdl};
    end

    dbell_chan_reg #(
      .PAY_W (PAY_W)
    ) chan_i (
      .clk    (clk),
      .rst_n  (rst_n),
      .fire_i (fire[g]),
      .pay_i  (pay_in),
      .vld_o  (ch_vld[g]),
      .pay_o  (ch_pay[g])
    );
  end

  dbell_chan_reg #(
    .PAY_W (PAGE_BITS)
  ) err_chan_i (
    .clk    (clk),
    .rst_n  (rst_n),
    .fire_i (bad_access),
    .pay_i  (page_off),
    .vld_o  (err_o),
    .pay_o  (err_off_o)
  );

  // Qualifier bit of the non-arm channels is always zero.
  logic unused_qual;
  assign unused_qual = ch_pay[CH_SEND][HDL_W] ^ ch_pay[CH_RECV][HDL_W] ^
                       ch_pay[CH_POLL][HDL_W];

  assign qp_send_o     = ch_vld[CH_SEND];
  assign qp_send_hdl_o = ch_pay[CH_SEND][HDL_W-1:0];
  assign qp_recv_o     = ch_vld[CH_RECV];
  assign qp_recv_hdl_o = ch_pay[CH_RECV][HDL_W-1:0];
  assign cq_arm_o      = ch_vld[CH_ARM];
  assign cq_arm_hdl_o  = ch_pay[CH_ARM][HDL_W-1:0];
  assign cq_arm_sol_o  = ch_pay[CH_ARM][HDL_W];
  assign cq_poll_o     = ch_vld[CH_POLL];
  assign cq_poll_hdl_o = ch_pay[CH_POLL][HDL_W-1:0];

endmodule

// File: rtl/ctx_doorbell_decode_chk.sv
module ctx_doorbell_decode_chk #(
  parameter int DATA_W    = 32,
  parameter int HDL_W     = 24,
  parameter int PAGE_BITS = 12,
  parameter int QP_OFF    = 'h000,
  parameter int CQ_OFF    = 'h008,
  parameter int SEND_BIT  = 30,
  parameter int RECV_BIT  = 31,
  parameter int ARM_BIT   = 30,
  parameter int SOL_BIT   = 29,
  parameter int POLL_BIT  = 31
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 wr_en,
  input logic [PAGE_BITS-1:0] wr_off,
  input logic [DATA_W-1:0]    wr_data,
  input logic [DATA_W/8-1:0]  wr_strb,
  input logic                 qp_send_o,
  input logic [HDL_W-1:0]     qp_send_hdl_o,
  input logic                 qp_recv_o,
  input logic [HDL_W-1:0]     qp_recv_hdl_o,
  input logic                 cq_arm_o,
  input logic                 cq_arm_sol_o,
  input logic                 cq_poll_o,
  input logic [HDL_W-1:0]     cq_poll_hdl_o,
  input logic                 err_o
);

  logic unused_chk_bits;
  assign unused_chk_bits = ^wr_data;

  logic full_wr, at_qp, at_cq, any_req;
  assign full_wr = wr_en && (&wr_strb);
  assign at_qp   = full_wr && (wr_off == PAGE_BITS'(QP_OFF));
  assign at_cq   = full_wr && (wr_off == PAGE_BITS'(CQ_OFF));
  assign any_req = qp_send_o || qp_recv_o || cq_arm_o || cq_poll_o;

  p_send_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (at_qp && wr_data[SEND_BIT]) |=>
      (qp_send_o && qp_send_hdl_o == $past(wr_data[HDL_W-1:0])));

  p_recv_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (at_qp && wr_data[RECV_BIT]) |=>
      (qp_recv_o && qp_recv_hdl_o == $past(wr_data[HDL_W-1:0])));

  p_arm_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (at_cq && wr_data[ARM_BIT]) |=>
      (cq_arm_o && cq_arm_sol_o == $past(wr_data[SOL_BIT])));

  p_poll_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (at_cq && wr_data[POLL_BIT]) |=>
      (cq_poll_o && cq_poll_hdl_o == $past(wr_data[HDL_W-1:0])));

  p_unsup_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (full_wr && !at_qp && !at_cq) |=> (err_o && !any_req));

  p_partial_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !(&wr_strb)) |=> (err_o && !any_req));

  p_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> (!any_req && !err_o));

  p_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (at_qp && !wr_data[SEND_BIT] && !wr_data[RECV_BIT]) |=> (!any_req && !err_o));

endmodule

bind ctx_doorbell_decode ctx_doorbell_decode_chk #(
  .DATA_W    (DATA_W),
  .HDL_W     (HDL_W),
  .PAGE_BITS (PAGE_BITS),
  .QP_OFF    (QP_OFF),
  .CQ_OFF    (CQ_OFF),
  .SEND_BIT  (SEND_BIT),
  .RECV_BIT  (RECV_BIT),
  .ARM_BIT   (ARM_BIT),
  .SOL_BIT   (SOL_BIT),
  .POLL_BIT  (POLL_BIT)
) chk_i (
  .clk           (clk),
  .rst_n         (rst_n),
  .wr_en         (wr_en),
  .wr_off        (wr_addr[PAGE_BITS-1:0]),
  .wr_data       (wr_data),
  .wr_strb       (wr_strb),
  .qp_send_o     (qp_send_o),
  .qp_send_hdl_o (qp_send_hdl_o),
  .qp_recv_o     (qp_recv_o),
  .qp_recv_hdl_o (qp_recv_hdl_o),
  .cq_arm_o      (cq_arm_o),
  .cq_arm_sol_o  (cq_arm_sol_o),
  .cq_poll_o     (cq_poll_o),
  .cq_poll_hdl_o (cq_poll_hdl_o),
  .err_o         (err_o)
);

// File: tb/ctx_doorbell_decode_tb_top.sv
`timescale 1ns/100ps
module ctx_doorbell_decode_tb_top;

  logic        clk;
  logic        rst_n;
  logic        wr_en;
  logic [31:0] wr_addr;
  logic [31:0] wr_data;
  logic [3:0]  wr_strb;
  logic        qp_send_o, qp_recv_o, cq_arm_o, cq_arm_sol_o, cq_poll_o, err_o;
  logic [23:0] qp_send_hdl_o, qp_recv_hdl_o, cq_arm_hdl_o, cq_poll_hdl_o;
  logic [11:0] err_off_o;

  int n_checks = 0;
  int n_errors = 0;

  ctx_doorbell_decode dut_i (
    .clk           (clk),
    .rst_n         (rst_n),
    .wr_en         (wr_en),
    .wr_addr       (wr_addr),
    .wr_data       (wr_data),
    .wr_strb       (wr_strb),
    .qp_send_o     (qp_send_o),
    .qp_send_hdl_o (qp_send_hdl_o),
    .qp_recv_o     (qp_recv_o),
    .qp_recv_hdl_o (qp_recv_hdl_o),
    .cq_arm_o      (cq_arm_o),
    .cq_arm_hdl_o  (cq_arm_hdl_o),
    .cq_arm_sol_o  (cq_arm_sol_o),
    .cq_poll_o     (cq_poll_o),
    .cq_poll_hdl_o (cq_poll_hdl_o),
    .err_o         (err_o),
    .err_off_o     (err_off_o)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  function automatic logic [4:0] strobes();
    return {qp_send_o, qp_recv_o, cq_arm_o, cq_poll_o, err_o};
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  // Drive one write on a falling edge; results are read one falling edge later.
  // exp order: {send, recv, arm, poll, err}
  task automatic ring(input string req, input logic [31:0] addr, input logic [31:0] data,
                      input logic [3:0] strb, input logic [4:0] exp,
                      input logic exp_sol, input logic [11:0] exp_off);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = addr; wr_data = data; wr_strb = strb;
    @(negedge clk);
    wr_en = 1'b0;
    check({req, " strobes"}, 32'(strobes()), 32'(exp));
    if (exp[4]) check({req, " send handle"}, 32'(qp_send_hdl_o), 32'(data[23:0]));
    if (exp[3]) check({req, " recv handle"}, 32'(qp_recv_hdl_o), 32'(data[23:0]));
    if (exp[2]) begin
      check({req, " arm handle"}, 32'(cq_arm_hdl_o), 32'(data[23:0]));
      check({req, " arm solicited"}, 32'(cq_arm_sol_o), 32'(exp_sol));
    end
    if (exp[1]) check({req, " poll handle"}, 32'(cq_poll_hdl_o), 32'(data[23:0]));
    if (exp[0]) check({req, " error offset"}, 32'(err_off_o), 32'(exp_off));
    @(negedge clk);
    check({"R9 drop after ", req}, 32'(strobes()), 32'h0);
  endtask

  task automatic t_reset();
    rst_n = 1'b0; wr_en = 1'b0; wr_addr = '0; wr_data = '0; wr_strb = '0;
    repeat (3) @(negedge clk);
    check("R1 strobes in reset", 32'(strobes()), 32'h0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 strobes after release", 32'(strobes()), 32'h0);
  endtask

  task automatic t_queue_pair();
    ring("R3 send+recv", 32'h0000_0000, 32'hC012_3456, 4'hF, 5'b11000, 1'b0, 12'h0);
    ring("R3 send only", 32'h0000_0000, 32'h4000_00A5, 4'hF, 5'b10000, 1'b0, 12'h0);
    ring("R3 recv only", 32'h0000_0000, 32'h80FF_FFFF, 4'hF, 5'b01000, 1'b0, 12'h0);
    ring("R6 junk bits", 32'h0000_0000, 32'h5F00_0042, 4'hF, 5'b10000, 1'b0, 12'h0);
  endtask

  task automatic t_comp_queue();
    ring("R4 arm solicited", 32'h0000_0008, 32'h6000_0777, 4'hF, 5'b00100, 1'b1, 12'h0);
    ring("R4 arm plain", 32'h0000_0008, 32'h4000_0778, 4'hF, 5'b00100, 1'b0, 12'h0);
    ring("R5 poll only", 32'h0000_0008, 32'h8000_1234, 4'hF, 5'b00010, 1'b0, 12'h0);
    ring("R5 poll+arm+sol", 32'h0000_0008, 32'hE0AB_CDEF, 4'hF, 5'b00110, 1'b1, 12'h0);
  endtask

  task automatic t_page_alias();
    ring("R2 upper page cq", 32'h5000_3008, 32'h4000_0099, 4'hF, 5'b00100, 1'b0, 12'h0);
    ring("R2 upper page qp", 32'hFFFF_F000, 32'hC000_0011, 4'hF, 5'b11000, 1'b0, 12'h0);
  endtask

  task automatic t_unsupported();
    ring("R7 offset 0x004", 32'h0000_0004, 32'hC000_0001, 4'hF, 5'b00001, 1'b0, 12'h004);
    ring("R7 offset 0xFFC", 32'h0000_7FFC, 32'hE000_0002, 4'hF, 5'b00001, 1'b0, 12'hFFC);
    ring("R7 offset 0x108", 32'h0000_0108, 32'h8000_0003, 4'hF, 5'b00001, 1'b0, 12'h108);
  endtask

  task automatic t_partial();
    ring("R8 half word qp", 32'h0000_0000, 32'hC000_0005, 4'h3, 5'b00001, 1'b0, 12'h000);
    ring("R8 byte cq", 32'h0000_0008, 32'hE000_0006, 4'h8, 5'b00001, 1'b0, 12'h008);
  endtask

  task automatic t_back_to_back();
    @(negedge clk);
    wr_en = 1'b1; wr_addr = 32'h0; wr_data = 32'h4000_0010; wr_strb = 4'hF;
    @(negedge clk);
    wr_data = 32'h4000_0020;
    check("R9 first of pair", 32'(strobes()), 32'(5'b10000));
    check("R9 first handle", 32'(qp_send_hdl_o), 32'h10);
    @(negedge clk);
    wr_en = 1'b0;
    check("R9 second of pair", 32'(strobes()), 32'(5'b10000));
    check("R9 second handle", 32'(qp_send_hdl_o), 32'h20);
    @(negedge clk);
    check("R9 pair dropped", 32'(strobes()), 32'h0);
    repeat (2) @(negedge clk);
    check("R9 idle stays low", 32'(strobes()), 32'h0);
  endtask

  task automatic t_no_action();
    ring("R10 qp bit29 only", 32'h0000_0000, 32'h2000_0001, 4'hF, 5'b00000, 1'b0, 12'h0);
    ring("R10 cq sol only", 32'h0000_0008, 32'h2000_0002, 4'hF, 5'b00000, 1'b0, 12'h0);
    ring("R10 no flags", 32'h0000_0008, 32'h00AB_CDEF, 4'hF, 5'b00000, 1'b0, 12'h0);
  endtask

  initial begin
    t_reset();
    t_queue_pair();
    t_comp_queue();
    t_page_alias();
    t_unsupported();
    t_partial();
    t_back_to_back();
    t_no_action();
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_checks++;
    n_errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
    $finish;
  end

endmodule